// File: doc/BRIEF.md
# Dual-path SPI clock divider

This block sits between a fast source clock and an SPI shift engine. It does not make a clock. Instead it raises a one-cycle strobe in the source clock domain at twice the rate of the serial clock, and the shift engine toggles its serial clock on each strobe. The serial-clock period therefore spans the full divide ratio, and the strobe fires once every half of that ratio.

Two divide laws are offered. A power-of-two law takes a narrow code N and divides by 2^(N+2). A linear law takes a wider code N and divides by 2·(N+1). A select input picks the law. The divide ratio now in force is shown on an output port so that neighbouring logic, such as sampling-delay tuning, can read it.

Configuration is shadowed. While the block runs, a new code or a new select only takes hold at a strobe boundary, so a serial-clock half period is never cut short. While the block is disabled, the counter is held cleared and the shadow follows the inputs.

Top module: `sclk_dual_divider`

## Requirements
- R1: With `lin_select` = 0, the effective ratio is 2^(`pow2_code`+2). Codes 0, 1, 2 and 3 give 4, 8, 16 and 32, and code 7 gives 512.
- R2: With `lin_select` = 1, the effective ratio is 2·(`lin_code`+1). Code 0 gives 2, code 9 gives 20 and code 255 gives 512.
- R3: The select bit alone decides which code is used. When the select bit is 0, a change to `lin_code` has no effect on `ratio`, and when it is 1, a change to `pow2_code` has no effect.
- R4: While enabled, `tick` is high in exactly one of every ratio/2 source cycles. With ratio 2 it is high in every cycle; otherwise it never stays high for two cycles in a row.
- R5: After `enable` rises, the first `tick` comes in the (ratio/2)-th enabled cycle, counting the first enabled cycle as 1.
- R6: A change to the codes or the select bit while enabled leaves `ratio` and the running half period unchanged up to and including the next `tick`. The new ratio applies from the cycle after that `tick`.
- R7: While `enable` is low, `tick` stays low and the counter is held cleared. `ratio` shows the configuration that was present at the previous clock edge.
- R8: During and right after reset, `tick` is low and `ratio` is 4, which is the power-of-two law with code 0.
- R9: Dropping `enable` for one cycle in the middle of a period restarts the count. The next `tick` then comes a full half ratio after re-enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the divider; low holds the counter cleared |
| pow2_code | input | POW2_W (3) | Power-of-two law code N, ratio 2^(N+2) |
| lin_code | input | LIN_W (8) | Linear law code N, ratio 2·(N+1) |
| lin_select | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| tick | output | 1 | One-cycle strobe at twice the serial-clock rate |
| ratio | output | RATIO_W (10) | Divide ratio currently in force |

## Verification
Both laws are tried at their smallest code, at a middle code and at their largest code, which checks the 2-cycle and 512-cycle extremes and the ratio width. One stimulus sets the two codes to different values and switches only the select bit, so that a mix-up between the two laws shows up. A code change in the middle of a period tells a shadowed design apart from one that reloads at once, and a one-cycle drop of `enable` tells a restarting counter apart from one that only pauses. A behavioural model compares `tick` and `ratio` on every clock against all of these patterns.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

   // Width needed for the largest ratio of either law
   function automatic int ratio_width(input int pow2_w, input int lin_w);
      int w_pow2;
      int w_lin;
      w_pow2 = (1 << pow2_w) + 2;   // largest ratio 2^(2^pow2_w + 1)
      w_lin  = lin_w + 2;           // largest ratio 2^(lin_w + 1)
      return (w_pow2 > w_lin) ? w_pow2 : w_lin;
   endfunction

   localparam int RESET_RATIO = 4;

endpackage

// File: rtl/sclk_pow2_law.sv
module sclk_pow2_law #(
   parameter int CODE_W  = 3,
   parameter int RATIO_W = 10
) (
   input  logic [CODE_W-1:0]  code,
   output logic [RATIO_W-1:0] ratio
);
   localparam int NCODES = 1 << CODE_W;

   // One-hot ratio: bit (code + 2) set
   always_comb begin
      ratio = '0;
      for (int i = 0; i < NCODES; i++) begin
         if (code == CODE_W'(i)) ratio[i+2] = 1'b1;
      end
   end
endmodule

// File: rtl/sclk_lin_law.sv
module sclk_lin_law #(
   parameter int CODE_W  = 8,
   parameter int RATIO_W = 10
) (
   input  logic [CODE_W-1:0]  code,
   output logic [RATIO_W-1:0] ratio
);
   logic [RATIO_W-1:0] steps;

   assign steps = RATIO_W'(code) + RATIO_W'(1);
   assign ratio = {steps[RATIO_W-2:0], 1'b0};
endmodule

// File: rtl/sclk_cfg_shadow.sv
module sclk_cfg_shadow #(
   parameter int RATIO_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RATIO_W-1:0] next_ratio,
   output logic [RATIO_W-1:0] ratio_q
);
   import sclk_div_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ratio_q <= RATIO_W'(RESET_RATIO);
      else if (load) ratio_q <= next_ratio;
   end
endmodule

// File: rtl/sclk_tick_counter.sv
module sclk_tick_counter #(
   parameter int HALF_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              tick
);
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] last;

   assign last = half - HALF_W'(1);
   assign tick = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + HALF_W'(1);
   end
endmodule

// File: rtl/sclk_dual_divider.sv
module sclk_dual_divider #(
   parameter int POW2_W  = 3,
   parameter int LIN_W   = 8,
   parameter int RATIO_W = sclk_div_pkg::ratio_width(POW2_W, LIN_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [POW2_W-1:0]  pow2_code,
   input  logic [LIN_W-1:0]   lin_code,
   input  logic               lin_select,
   output logic               tick,
   output logic [RATIO_W-1:0] ratio
);
   import sclk_div_pkg::*;

   localparam int HALF_W = RATIO_W - 1;

   generate
      if (POW2_W < 1 || POW2_W > 4) begin : g_bad_pow2
         $error("POW2_W must lie in 1..4");
      end
      if (LIN_W < 2 || LIN_W > 16) begin : g_bad_lin
         $error("LIN_W must lie in 2..16");
      end
      if (RATIO_W < ratio_width(POW2_W, LIN_W)) begin : g_bad_ratio
         $error("RATIO_W too narrow for the largest ratio");
      end
   endgenerate

   logic [RATIO_W-1:0] pow2_ratio;
   logic [RATIO_W-1:0] lin_ratio;
   logic [RATIO_W-1:0] chosen_ratio;
   logic               load_cfg;
   div_law_e           law;

   sclk_pow2_law #(.CODE_W(POW2_W), .RATIO_W(RATIO_W)) u_pow2 (
      .code  (pow2_code),
      .ratio (pow2_ratio)
   );

   sclk_lin_law #(.CODE_W(LIN_W), .RATIO_W(RATIO_W)) u_lin (
      .code  (lin_code),
      .ratio (lin_ratio)
   );

   assign law          = div_law_e'(lin_select);
   assign chosen_ratio = (law == LAW_LINEAR) ? lin_ratio : pow2_ratio;

   // Reload only at a half-period boundary or while idle
   assign load_cfg = !enable || tick;

   sclk_cfg_shadow #(.RATIO_W(RATIO_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_cfg),
      .next_ratio (chosen_ratio),
      .ratio_q    (ratio)
   );

   sclk_tick_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (enable),
      .half  (ratio[RATIO_W-1:1]),
      .tick  (tick)
   );
endmodule

// File: rtl/sclk_dual_divider_chk.sv
module sclk_dual_divider_chk #(
   parameter int POW2_W  = 3,
   parameter int LIN_W   = 8,
   parameter int RATIO_W = sclk_div_pkg::ratio_width(POW2_W, LIN_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic [POW2_W-1:0]  pow2_code,
   input logic [LIN_W-1:0]   lin_code,
   input logic               lin_select,
   input logic               tick,
   input logic [RATIO_W-1:0] ratio
);
   logic warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm <= 1'b0;
      else        warm <= 1'b1;
   end

   // R7: no strobe while disabled
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !tick);

   // R4: strobes are isolated unless the ratio is 2
   a_r4_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || ratio == RATIO_W'(2)));

   // R6: ratio holds while running between strobes
   a_r6_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && enable && $past(enable) && !$past(tick)) |-> $stable(ratio));

   // R1: power-of-two law seen after an idle cycle
   a_r1_pow2_law: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(enable) && !$past(lin_select))
      |-> ratio == (RATIO_W'(1) << (int'($past(pow2_code)) + 2)));

   // R2: linear law seen after an idle cycle
   a_r2_lin_law: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(enable) && $past(lin_select))
      |-> ratio == ((RATIO_W'($past(lin_code)) + RATIO_W'(1)) << 1));
endmodule

bind sclk_dual_divider sclk_dual_divider_chk #(
   .POW2_W  (POW2_W),
   .LIN_W   (LIN_W),
   .RATIO_W (RATIO_W)
) u_chk (.*);

// File: tb/sclk_dual_divider_bench.sv
module sclk_dual_divider_bench;
   localparam int CLK_P   = 10;
   localparam int POW2_W  = 3;
   localparam int LIN_W   = 8;
   localparam int RATIO_W = sclk_div_pkg::ratio_width(POW2_W, LIN_W);

   logic               clk = 1'b0;
   logic               rst_n;
   logic               enable;
   logic [POW2_W-1:0]  pow2_code;
   logic [LIN_W-1:0]   lin_code;
   logic               lin_select;
   logic               tick;
   logic [RATIO_W-1:0] ratio;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // model state
   int m_cnt   = 0;
   int m_ratio = 4;

   always #(CLK_P/2) clk = ~clk;

   sclk_dual_divider #(.POW2_W(POW2_W), .LIN_W(LIN_W)) u_sclk_dual_divider (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .pow2_code  (pow2_code),
      .lin_code   (lin_code),
      .lin_select (lin_select),
      .tick       (tick),
      .ratio      (ratio)
   );

   function automatic int law_ratio(int pc, int lc, bit sel);
      if (sel) return (lc + 1) * 2;
      return 1 << (pc + 2);
   endfunction

   function automatic bit model_tick();
      return enable && (m_cnt == m_ratio / 2 - 1);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model update
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt   = 0;
         m_ratio = 4;
      end else if (!enable || model_tick()) begin
         m_cnt   = 0;
         m_ratio = law_ratio(int'(pow2_code), int'(lin_code), lin_select);
      end else begin
         m_cnt++;
      end
   end

   // Per-clock comparison
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check(tick === model_tick(), "R4 R5 R6 R7 R9 tick", int'(tick), int'(model_tick()));
         check(int'(ratio) == m_ratio, "R1 R2 R3 R6 ratio", int'(ratio), m_ratio);
      end
   end

   task automatic drive(bit en, int pc, int lc, bit sel);
      @(posedge clk);
      #1;
      enable     = en;
      pow2_code  = POW2_W'(pc);
      lin_code   = LIN_W'(lc);
      lin_select = sel;
   endtask

   task automatic cycles_to_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (tick !== 1'b1 && n < 2000);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      rst_n = 1'b0; enable = 1'b0; pow2_code = '0; lin_code = '0; lin_select = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(tick === 1'b0, "R8 reset tick", int'(tick), 0);
         check(int'(ratio) == 4, "R8 reset ratio", int'(ratio), 4);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(int'(ratio) == 4 && tick === 1'b0, "R8 after reset", int'(ratio), 4);

      // R5 R1: code 0
      drive(1, 0, 0, 0);
      cycles_to_tick(n); check(n == 2, "R5 first tick code0", n, 2);
      check(int'(ratio) == 4, "R1 code0 ratio", int'(ratio), 4);
      cycles_to_tick(n); check(n == 2, "R4 gap code0", n, 2);

      // R1: code 3
      drive(0, 3, 0, 0); drive(1, 3, 0, 0);
      cycles_to_tick(n); check(n == 16, "R1 code3 first tick", n, 16);
      check(int'(ratio) == 32, "R1 code3 ratio", int'(ratio), 32);

      // R1: code 7
      drive(0, 7, 0, 0); drive(1, 7, 0, 0);
      cycles_to_tick(n); check(n == 256, "R1 code7 first tick", n, 256);
      check(int'(ratio) == 512, "R1 code7 ratio", int'(ratio), 512);

      // R2 R3: linear code 9
      drive(0, 7, 9, 1); drive(1, 7, 9, 1);
      cycles_to_tick(n); check(n == 10, "R2 lin9 first tick", n, 10);
      check(int'(ratio) == 20, "R3 lin selected ratio", int'(ratio), 20);
      cycles_to_tick(n); check(n == 10, "R4 gap lin9", n, 10);

      // R3: select low ignores linear code
      drive(0, 1, 4, 0); drive(1, 1, 4, 0);
      cycles_to_tick(n); check(n == 4, "R3 pow2 selected tick", n, 4);
      check(int'(ratio) == 8, "R3 pow2 selected ratio", int'(ratio), 8);

      // R2 R4: linear code 0, tick every cycle
      drive(0, 1, 0, 1); drive(1, 1, 0, 1);
      cycles_to_tick(n); check(n == 1, "R2 lin0 first tick", n, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(tick === 1'b1, "R4 ratio2 continuous", int'(tick), 1);
      end

      // R2: linear code 255
      drive(0, 0, 255, 1); drive(1, 0, 255, 1);
      cycles_to_tick(n); check(n == 256, "R2 lin255 first tick", n, 256);
      check(int'(ratio) == 512, "R2 lin255 ratio", int'(ratio), 512);

      // R6: change mid-period
      drive(0, 0, 9, 1); drive(1, 0, 9, 1);
      cycles_to_tick(n); check(n == 10, "R6 setup tick", n, 10);
      repeat (3) @(posedge clk);
      #1 lin_code = LIN_W'(2);
      @(negedge clk);
      check(int'(ratio) == 20, "R6 ratio held mid-period", int'(ratio), 20);
      cycles_to_tick(n); check(n == 7, "R6 old period completes", n, 7);
      check(int'(ratio) == 20, "R6 ratio held at tick", int'(ratio), 20);
      cycles_to_tick(n); check(n == 3, "R6 new period", n, 3);
      check(int'(ratio) == 6, "R6 new ratio", int'(ratio), 6);

      // R7: disabled
      drive(0, 0, 2, 1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(tick === 1'b0, "R7 idle tick low", int'(tick), 0);
      end
      @(posedge clk); #1 lin_code = LIN_W'(5);
      @(negedge clk);
      check(int'(ratio) == 6, "R7 ratio before edge", int'(ratio), 6);
      @(negedge clk);
      check(int'(ratio) == 12, "R7 ratio follows idle input", int'(ratio), 12);

      // R9: restart after a one-cycle drop
      drive(1, 0, 9, 1);
      repeat (4) @(posedge clk);
      #1 enable = 1'b0;
      @(posedge clk); #1 enable = 1'b1;
      cycles_to_tick(n); check(n == 10, "R9 restart full period", n, 10);

      repeat (5) @(posedge clk);
      finish_run();
   end
endmodule